// File: doc/BRIEF.md
# Serial Four-Bit Group Even-Parity Detector

This block watches a serial bit stream, one bit per clock, and cuts it into back-to-back groups of four bits that do not overlap. For each group it keeps a running count of ones, reduced to a single parity bit. When the fourth bit of a group arrives, the block raises its output flag for one cycle if that group held an even number of ones. The flag is a registered Moore output, so it appears on the cycle after the fourth bit is sampled.

There are no gap cycles between groups. The first bit of the next group is taken in during the same cycle that the previous group's result is shown. A synchronous reset fixes where the groups start: the first bit sampled after reset is the first bit of a new group. A typical use is a framing or integrity check on a slow serial link, where a downstream controller only needs a per-group "parity good" strobe.

Top module: `nib_even_det`

## Requirements
- R1: While `rst` is high at a rising edge, `even_flag` is 0 on the following cycle. The first `ser_in` bit sampled with `rst` low is bit one of a new group.
- R2: Groups are consecutive and non-overlapping. Every fourth sampled bit after reset closes a group, and the next sampled bit opens the next group.
- R3: When a group closes with an even number of ones (`ser_in` = 1 counts as a one), `even_flag` is 1 in the cycle after the edge that sampled the group's fourth bit.
- R4: When a group closes with an odd number of ones, `even_flag` stays 0 in that cycle.
- R5: In the cycles that follow the sampling of the first, second or third bit of a group, `even_flag` is 0.
- R6: A group of four zeros counts as even, because it holds zero ones, and produces a 1.
- R7: A flag pulse lasts exactly one cycle. While it is shown, the next group's first bit is absorbed, so two even groups in a row give pulses exactly four cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; realigns the group boundary |
| ser_in | input | 1 | Serial data bit, one per clock |
| even_flag | output | 1 | Registered one-cycle pulse: the group that just closed had even parity |

## Verification
The bench builds the block with its default group length of four. With that length, a reference model that only counts positions and ones can follow every group boundary, and a few thousand random bits cover all sixteen group patterns many times over. Directed sequences cover the all-zero and all-one groups, back-to-back even groups, and a reset issued in the middle of a group. That last case shows that group alignment restarts from reset.

// File: rtl/nib_par_pkg.sv
package nib_par_pkg;

  // Parity after folding one more bit into the running parity.
  function automatic logic fold_bit(input logic par, input logic bit_in);
    return par ^ bit_in;
  endfunction

  // A group is even when its folded parity is zero.
  function automatic logic is_even(input logic par);
    return ~par;
  endfunction

endpackage

// File: rtl/nib_pos_ctr.sv
module nib_pos_ctr #(
  parameter int GROUP_LEN = 4,
  localparam int CNT_W = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos_o,
  output logic             frame_end_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_LEN - 1);

  logic [CNT_W-1:0] pos_q;

  assign frame_end_o = (pos_q == LAST);
  assign pos_o       = pos_q;

  always_ff @(posedge clk) begin
    if (rst)              pos_q <= '0;
    else if (frame_end_o) pos_q <= '0;
    else                  pos_q <= pos_q + CNT_W'(1);
  end
endmodule

// File: rtl/nib_par_acc.sv
module nib_par_acc
  import nib_par_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic clear_i,
  output logic par_next_o
);
  logic par_q;

  assign par_next_o = fold_bit(par_q, bit_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) par_q <= 1'b0;
    else                par_q <= par_next_o;
  end
endmodule

// File: rtl/nib_even_det.sv
module nib_even_det
  import nib_par_pkg::*;
#(
  parameter int GROUP_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  output logic even_flag
);
  localparam int CNT_W = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1;

  logic [CNT_W-1:0] pos;
  logic             frame_end;
  logic             par_next;
  logic             flag_q;

  nib_pos_ctr #(.GROUP_LEN(GROUP_LEN)) pos_i (
    .clk         (clk),
    .rst         (rst),
    .pos_o       (pos),
    .frame_end_o (frame_end)
  );

  nib_par_acc par_i (
    .clk        (clk),
    .rst        (rst),
    .bit_i      (ser_in),
    .clear_i    (frame_end),
    .par_next_o (par_next)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= frame_end & is_even(par_next);
  end

  assign even_flag = flag_q;

  logic unused_pos;
  assign unused_pos = ^pos;
endmodule

// File: rtl/nib_even_chk.sv
module nib_even_chk #(
  parameter int GROUP_LEN = 4,
  localparam int CNT_W = (GROUP_LEN > 2) ? $clog2(GROUP_LEN) : 1,
  localparam int SHW = GROUP_LEN - 1
) (
  input logic clk,
  input logic rst,
  input logic ser_in,
  input logic even_flag,
  input logic frame_end
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP_LEN - 1);

  logic [CNT_W-1:0] ph_q;
  logic [SHW-1:0]   sh_q;
  logic             was_rst_q;

  always_ff @(posedge clk) begin
    was_rst_q <= rst;
    if (rst) begin
      ph_q <= '0;
      sh_q <= '0;
    end else begin
      ph_q <= (ph_q == LAST) ? '0 : ph_q + CNT_W'(1);
      sh_q <= (sh_q << 1) | SHW'(ser_in);
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (was_rst_q) reset_flag_low_chk: assert (!even_flag);
  end

  // R2
  group_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end == (ph_q == LAST));

  // R3
  group_parity_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (even_flag == ~(^{$past(sh_q), $past(ser_in)})));

  // R5
  mid_group_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> !even_flag);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    even_flag |=> !even_flag);
endmodule

bind nib_even_det nib_even_chk #(.GROUP_LEN(GROUP_LEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ser_in    (ser_in),
  .even_flag (even_flag),
  .frame_end (frame_end)
);

// File: tb/nib_even_det_tb_top.sv
`timescale 1ns/1ps
module nib_even_det_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic even_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int pos_m  = 0;
  int ones_m = 0;
  bit exp_m  = 0;
  bit prev_exp = 0;
  int last_pulse = -100;
  int pulse_cnt = 0;

  always #4 clk = ~clk;   // 125 MHz

  nib_even_det dut_i (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .even_flag (even_flag)
  );

  always @(posedge clk) cycles++;

  task automatic check(input bit got, input bit want, input string req);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: even_flag=%0b expected %0b (cycle %0d)", req, got, want, cycles);
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
    check(even_flag, 1'b0, "R1");
    rst = 1'b0;
    pos_m = 0; ones_m = 0; exp_m = 0; prev_exp = 0;
  endtask

  // drive one bit at negedge, let the edge sample it, check at next negedge
  task automatic step(input bit b);
    bit closing;
    closing = (pos_m == 3);
    ser_in = b;
    @(posedge clk);
    prev_exp = exp_m;
    if (closing) begin
      ones_m += b;
      exp_m = ((ones_m % 2) == 0);
      pos_m = 0; ones_m = 0;
    end else begin
      ones_m += b;
      pos_m++;
      exp_m = 0;
    end
    @(negedge clk);
    if (exp_m) begin
      pulse_cnt++;
      last_pulse = cycles;
    end
    if (prev_exp && !closing) check(even_flag, exp_m, "R7");
    else if (!closing)        check(even_flag, exp_m, "R5");
    else if (exp_m)           check(even_flag, exp_m, "R3");
    else                      check(even_flag, exp_m, "R4");
  endtask

  task automatic feed(input logic [3:0] g);
    for (int i = 3; i >= 0; i--) step(g[i]);
  endtask

  initial begin
    int p0;
    int t0;
    @(negedge clk);
    do_reset(3);

    // worked example: 0111 1000 1010 -> one pulse after third group (R2)
    p0 = pulse_cnt;
    feed(4'b0111);
    feed(4'b1000);
    feed(4'b1010);
    checks++;
    if (pulse_cnt - p0 != 1) begin
      errors++;
      $display("FAIL R2: pulses=%0d expected 1", pulse_cnt - p0);
    end

    // all-zero groups, back to back (R6, R7)
    feed(4'b0000);
    checks++;
    if (last_pulse != cycles || even_flag !== 1'b1) begin
      errors++;
      $display("FAIL R6: even_flag=%0b expected 1", even_flag);
    end
    t0 = last_pulse;
    feed(4'b0000);
    checks++;
    if (last_pulse - t0 != 4) begin
      errors++;
      $display("FAIL R7: pulse spacing=%0d expected 4", last_pulse - t0);
    end

    // all ones (even), single ones (odd), three ones (odd)
    feed(4'b1111);
    feed(4'b0010);
    feed(4'b1101);
    feed(4'b0110);

    // reset in mid-group realigns boundaries (R1, R2)
    step(1'b1);
    step(1'b1);
    do_reset(1);
    feed(4'b1000);
    feed(4'b0000);
    checks++;
    if (even_flag !== 1'b1) begin
      errors++;
      $display("FAIL R2: even_flag=%0b expected 1 after realigned group", even_flag);
    end

    // random stream
    for (int i = 0; i < 3000; i++) step(1'($urandom_range(0, 1)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, cycles=%0d expected < 100000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule